// File: doc/BRIEF.md
# Asynchronous SRAM Port Controller

This block sits between a synchronous host and an external byte-wide asynchronous static RAM of 8192 locations. The host hands over one read or write at a time. The controller turns each request into registered strobes for the memory: an active-low select, an active-high select, a write strobe and a read-output gate. Every minimum timing window of the memory is met by counting clock cycles. Each count is the ceiling of a nanosecond parameter divided by the clock period, so only the parameters change when the clock frequency changes.

The request side follows valid/ready rules. A request is taken on a rising edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while the controller is idle and power is good. The host must hold `req_valid`, `req_write`, `req_addr` and `req_wdata` steady while it waits. The response side has no back-pressure: `rsp_valid` is a single-cycle pulse that the host must take. The memory data pins are split into an output value, a drive enable and an input value, and the pad ring joins them into a tristate pin. While `pwr_good` is low, the memory stays deselected and no request is taken.

Top module: `sram_async_port`

## Requirements
- R1: While reset is active, `mem_cs` is 0 and `mem_cs_n`, `mem_we_n` and `mem_oe_n` are 1, `mem_dq_oe` is 0 and `req_ready` is 0. Any clock edge that samples `pwr_good` low deselects the memory (`mem_cs`=0) from that edge on. `req_ready` rises only after `pwr_good` has been sampled high on NCYC = ceil(150 ns / period) consecutive edges (8 at 20 ns). The memory is never selected earlier than 150 ns after `pwr_good` rises.
- R2: `req_ready` is 1 exactly when the controller is idle and `pwr_good` is 1. A request is accepted on the edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 from that edge until the cycle is fully finished, and a held request waits without being lost.
- R3: A read asserts both selects and drives `mem_oe_n` low from the acceptance edge for RDL = max(ceil(150/period), ceil(70/period)) cycles (8 at 20 ns), with `mem_we_n` held high. When idle, `mem_we_n`=1, `mem_oe_n`=1 and `mem_dq_oe`=0.
- R4: Read data is sampled on the edge that ends the access window. `rsp_valid` is 1 for exactly one cycle, RDL edges after acceptance, and `rsp_rdata` equals the byte last written to that address. A write never produces `rsp_valid`.
- R5: After `mem_oe_n` rises, the controller does not drive the data bus for at least 50 ns. A read holds `req_ready` low for max(ceil(50/period), NCYC-RDL) cycles after the access window, giving 11 cycles in total at 20 ns.
- R6: A write pulls `mem_we_n` low from the acceptance edge for WPL = max(ceil(90/period), ceil(60/period)) cycles (5 at 20 ns). `mem_oe_n` stays high for the whole write, and both selects are asserted while `mem_we_n` is low.
- R7: `mem_dq_oe` is 1 only from the falling edge of `mem_we_n` until ceil(5/period) cycles after its rising edge. `mem_dq_out` does not change while it is driven. The data is stable at least 60 ns before `mem_we_n` rises.
- R8: `mem_addr` changes only on an acceptance edge, and it stays put for at least 10 ns after `mem_we_n` rises. A write keeps `req_ready` low for WPL + max(1, NCYC-WPL) cycles (8 at 20 ns).
- R9: Consecutive changes of `mem_addr` are at least 150 ns apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_good | input | 1 | Memory supply reported good |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 13 | Request byte address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | One-cycle read data strobe |
| rsp_rdata | output | 8 | Read data |
| mem_addr | output | 13 | Memory address |
| mem_cs_n | output | 1 | Memory select, active low |
| mem_cs | output | 1 | Memory select, active high |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_oe_n | output | 1 | Memory output gate, active low |
| mem_dq_out | output | 8 | Data toward memory |
| mem_dq_oe | output | 1 | Drive enable for data pins |
| mem_dq_in | input | 8 | Data from memory pins |

## Verification
At 20 ns, read data is due on `rsp_valid` 8 edges after acceptance. `req_ready` returns 11 edges after a read is accepted and 8 edges after a write. After reset or a power drop, `req_ready` rises on the 8th edge with `pwr_good` high. The bench drives inputs at falling edges. A behavioural model steps once for every rising edge, and the next falling edge compares the ports against it, so every result is checked in the cycle it is due. A separate memory model records strobe event times in nanoseconds to check each window. It returns corrupted data when it is sampled before its access time has passed.

// File: rtl/sram_ctrl_pkg.sv
`timescale 1ns/1ps
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_PWR  = 3'd0,
    ST_IDLE = 3'd1,
    ST_RD   = 3'd2,
    ST_FLT  = 3'd3,
    ST_WP   = 3'd4,
    ST_WREC = 3'd5
  } ctl_state_e;

  function automatic int cdiv(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_ctrl_timer.sv
`timescale 1ns/1ps
module sram_ctrl_timer #(
  parameter int CW       = 4,
  parameter int INIT_VAL = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic [CW-1:0] cnt,
  output logic          zero
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= CW'(INIT_VAL);
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);

endmodule

// File: rtl/sram_ctrl_fsm.sv
`timescale 1ns/1ps
module sram_ctrl_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int CYC_LEN = 8,
  parameter int RD_LEN  = 8,
  parameter int FLT_LEN = 3,
  parameter int WP_LEN  = 5,
  parameter int REC_LEN = 3,
  parameter int DH_LEN  = 1,
  parameter int CW      = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_good,
  input  logic req_valid,
  input  logic req_write,
  output logic ready,
  output logic accept,
  output logic capture,
  output logic sel_nxt,
  output logic oe_nxt,
  output logic we_nxt,
  output logic drive_nxt
);

  ctl_state_e    st_q, st_d;
  logic          ld;
  logic [CW-1:0] ld_val;
  logic [CW-1:0] cnt_q;
  logic          cnt_zero;

  sram_ctrl_timer #(.CW(CW), .INIT_VAL(CYC_LEN - 1)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ld),
    .load_val (ld_val),
    .cnt      (cnt_q),
    .zero     (cnt_zero)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_PWR;
    else        st_q <= st_d;
  end

  assign ready = (st_q == ST_IDLE) && pwr_good;

  always_comb begin
    st_d    = st_q;
    ld      = 1'b0;
    ld_val  = '0;
    accept  = 1'b0;
    capture = 1'b0;
    if (!pwr_good) begin
      st_d   = ST_PWR;
      ld     = 1'b1;
      ld_val = CW'(CYC_LEN - 1);
    end else begin
      unique case (st_q)
        ST_PWR:  if (cnt_zero) st_d = ST_IDLE;
        ST_IDLE: if (req_valid) begin
          accept = 1'b1;
          ld     = 1'b1;
          if (req_write) begin
            st_d   = ST_WP;
            ld_val = CW'(WP_LEN - 1);
          end else begin
            st_d   = ST_RD;
            ld_val = CW'(RD_LEN - 1);
          end
        end
        ST_RD: if (cnt_zero) begin
          capture = 1'b1;
          st_d    = ST_FLT;
          ld      = 1'b1;
          ld_val  = CW'(FLT_LEN - 1);
        end
        ST_FLT: if (cnt_zero) st_d = ST_IDLE;
        ST_WP: if (cnt_zero) begin
          st_d   = ST_WREC;
          ld     = 1'b1;
          ld_val = CW'(REC_LEN - 1);
        end
        ST_WREC: if (cnt_zero) st_d = ST_IDLE;
        default: st_d = ST_PWR;
      endcase
    end
  end

  // strobe levels for the cycle that follows the coming edge
  always_comb begin
    sel_nxt   = (st_d == ST_RD) || (st_d == ST_WP) || (st_d == ST_WREC);
    oe_nxt    = (st_d == ST_RD);
    we_nxt    = (st_d == ST_WP);
    drive_nxt = 1'b0;
    if (st_d == ST_WP) begin
      drive_nxt = 1'b1;
    end else if (st_d == ST_WREC) begin
      if (st_q == ST_WP) drive_nxt = (DH_LEN > 0);
      else               drive_nxt = ((REC_LEN - int'(cnt_q)) < DH_LEN);
    end
  end

endmodule

// File: rtl/sram_ctrl_phy.sv
`timescale 1ns/1ps
module sram_ctrl_phy #(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              capture,
  input  logic              sel_nxt,
  input  logic              oe_nxt,
  input  logic              we_nxt,
  input  logic              drive_nxt,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs_n,
  output logic              mem_cs,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_addr   <= '0;
      mem_dq_out <= '0;
    end else if (accept) begin
      mem_addr   <= req_addr;
      mem_dq_out <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_cs_n  <= 1'b1;
      mem_cs    <= 1'b0;
      mem_we_n  <= 1'b1;
      mem_oe_n  <= 1'b1;
      mem_dq_oe <= 1'b0;
    end else begin
      mem_cs_n  <= ~sel_nxt;
      mem_cs    <= sel_nxt;
      mem_we_n  <= ~we_nxt;
      mem_oe_n  <= ~oe_nxt;
      mem_dq_oe <= drive_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= capture;
      if (capture) rsp_rdata <= mem_dq_in;
    end
  end

endmodule

// File: rtl/sram_async_port.sv
`timescale 1ns/1ps
module sram_async_port
  import sram_ctrl_pkg::*;
#(
  parameter int CLK_PERIOD_NS = 20,
  parameter int ADDR_W        = 13,
  parameter int DATA_W        = 8,
  parameter int T_CYC_NS      = 150,
  parameter int T_ACC_NS      = 150,
  parameter int T_OE_NS       = 70,
  parameter int T_WP_NS       = 90,
  parameter int T_DS_NS       = 60,
  parameter int T_DH_NS       = 5,
  parameter int T_WR_NS       = 10,
  parameter int T_HZ_NS       = 50
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_good,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs_n,
  output logic              mem_cs,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);

  localparam int CYC_LEN = imax(1, cdiv(T_CYC_NS, CLK_PERIOD_NS));
  localparam int RD_LEN  = imax(1, imax(cdiv(T_ACC_NS, CLK_PERIOD_NS),
                                        cdiv(T_OE_NS, CLK_PERIOD_NS)));
  localparam int FLT_LEN = imax(imax(1, cdiv(T_HZ_NS, CLK_PERIOD_NS)), CYC_LEN - RD_LEN);
  localparam int WP_LEN  = imax(1, imax(cdiv(T_WP_NS, CLK_PERIOD_NS),
                                        cdiv(T_DS_NS, CLK_PERIOD_NS)));
  localparam int DH_LEN  = imax(1, cdiv(T_DH_NS, CLK_PERIOD_NS));
  localparam int REC_LEN = imax(imax(DH_LEN, imax(1, cdiv(T_WR_NS, CLK_PERIOD_NS))),
                                CYC_LEN - WP_LEN);
  localparam int MAX_LEN = imax(imax(CYC_LEN, RD_LEN), imax(imax(FLT_LEN, WP_LEN), REC_LEN));
  localparam int CW      = $clog2(MAX_LEN + 1);

  logic accept, capture;
  logic sel_nxt, oe_nxt, we_nxt, drive_nxt;

  sram_ctrl_fsm #(
    .CYC_LEN (CYC_LEN),
    .RD_LEN  (RD_LEN),
    .FLT_LEN (FLT_LEN),
    .WP_LEN  (WP_LEN),
    .REC_LEN (REC_LEN),
    .DH_LEN  (DH_LEN),
    .CW      (CW)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .pwr_good  (pwr_good),
    .req_valid (req_valid),
    .req_write (req_write),
    .ready     (req_ready),
    .accept    (accept),
    .capture   (capture),
    .sel_nxt   (sel_nxt),
    .oe_nxt    (oe_nxt),
    .we_nxt    (we_nxt),
    .drive_nxt (drive_nxt)
  );

  sram_ctrl_phy #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_phy (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (accept),
    .capture    (capture),
    .sel_nxt    (sel_nxt),
    .oe_nxt     (oe_nxt),
    .we_nxt     (we_nxt),
    .drive_nxt  (drive_nxt),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .mem_dq_in  (mem_dq_in),
    .mem_addr   (mem_addr),
    .mem_cs_n   (mem_cs_n),
    .mem_cs     (mem_cs),
    .mem_we_n   (mem_we_n),
    .mem_oe_n   (mem_oe_n),
    .mem_dq_out (mem_dq_out),
    .mem_dq_oe  (mem_dq_oe),
    .rsp_valid  (rsp_valid),
    .rsp_rdata  (rsp_rdata)
  );

endmodule

// File: rtl/sram_port_checker.sv
`timescale 1ns/1ps
module sram_port_checker #(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pwr_good,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_cs_n,
  input logic              mem_cs,
  input logic              mem_we_n,
  input logic              mem_oe_n,
  input logic [DATA_W-1:0] mem_dq_out,
  input logic              mem_dq_oe
);

  AST_POWER_LOW_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_good |=> !mem_cs);  // R1

  AST_READY_QUIET_PINS: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_we_n && mem_oe_n && !mem_dq_oe));  // R2

  AST_RSP_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);  // R4

  AST_WE_WITHOUT_OE: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (mem_oe_n && mem_cs && !mem_cs_n));  // R6

  AST_DRIVE_ONLY_OE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n);  // R7

  AST_DRIVE_DATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_dq_oe && $past(mem_dq_oe)) |-> $stable(mem_dq_out));  // R7

  AST_ADDR_MOVES_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_addr != $past(mem_addr)) |-> $past(req_valid && req_ready));  // R8

endmodule

bind sram_async_port sram_port_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pwr_good   (pwr_good),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .rsp_valid  (rsp_valid),
  .mem_addr   (mem_addr),
  .mem_cs_n   (mem_cs_n),
  .mem_cs     (mem_cs),
  .mem_we_n   (mem_we_n),
  .mem_oe_n   (mem_oe_n),
  .mem_dq_out (mem_dq_out),
  .mem_dq_oe  (mem_dq_oe)
);

// File: tb/sim_sram_async_port.sv
`timescale 1ns/1ps
module sim_sram_async_port;

  localparam int PER  = 20;
  localparam int NCYC = (150 + PER - 1) / PER;
  localparam int RDA  = (150 + PER - 1) / PER;
  localparam int RDO  = (70 + PER - 1) / PER;
  localparam int RDL  = (RDA > RDO) ? RDA : RDO;
  localparam int HZC  = (50 + PER - 1) / PER;
  localparam int RTOT = RDL + ((HZC > NCYC - RDL) ? HZC : NCYC - RDL);
  localparam int WPA  = (90 + PER - 1) / PER;
  localparam int WPD  = (60 + PER - 1) / PER;
  localparam int WPL  = (WPA > WPD) ? WPA : WPD;
  localparam int WTOT = WPL + ((NCYC - WPL > 1) ? NCYC - WPL : 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr_good = 1'b0;
  logic req_valid = 1'b0;
  logic req_write = 1'b0;
  logic [12:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic req_ready, rsp_valid;
  logic [7:0] rsp_rdata;
  logic [12:0] mem_addr;
  logic mem_cs_n, mem_cs, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [7:0] mem_dq_out;
  logic [7:0] mem_dq_in = '0;

  always #(PER/2) clk = ~clk;

  sram_async_port u0 (
    .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_cs(mem_cs),
    .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  int compared = 0;
  int mismatched = 0;
  bit done = 0;
  bit armed = 0;

  task automatic chk(input bit ok, input string what, input longint act, input longint exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s at %0t: actual=%0d expected=%0d", what, $time, act, exp);
    end
  endtask

  // ---------------- memory model with timing windows ----------------
  logic [7:0] sram   [0:8191];
  logic [7:0] shadow [0:8191];
  time t_wf = 0, t_wr = 0, t_dchg = 0, t_oer = 0, t_ofl = 0, t_achg = 0, t_sel = 0, t_pg = 0;
  bit  wf_seen = 0, wr_seen = 0;
  wire sel = !mem_cs_n && mem_cs;

  initial begin
    for (int i = 0; i < 8192; i++) begin sram[i] = 8'h00; shadow[i] = 8'h00; end
  end

  always @(posedge pwr_good) t_pg = $time;
  always @(posedge mem_oe_n) t_oer = $time;
  always @(negedge mem_oe_n) t_ofl = $time;

  always @(posedge sel) if (armed) begin
    t_sel = $time;
    chk(pwr_good && ($time - t_pg) >= 150, "R1 select after power good (ns)", $time - t_pg, 150);
  end

  always @(negedge mem_we_n) if (armed) begin
    t_wf = $time; wf_seen = 1;
    chk(mem_oe_n == 1'b1, "R6 output gate high at write start", mem_oe_n, 1);
  end

  always @(posedge mem_we_n) if (armed && wf_seen) begin
    chk(($time - t_wf) >= 90, "R6 write pulse width (ns)", $time - t_wf, 90);
    chk(mem_dq_oe == 1'b1, "R7 bus driven at write end", mem_dq_oe, 1);
    chk(($time - t_dchg) >= 60, "R7 data setup (ns)", $time - t_dchg, 60);
    sram[mem_addr] = mem_dq_out;
    t_wr = $time; wr_seen = 1;
  end

  always @(mem_dq_out) if (armed && mem_dq_oe) begin
    t_dchg = $time;
    if (mem_we_n && wr_seen && t_wr > t_wf)
      chk(($time - t_wr) >= 5, "R7 data hold on change (ns)", $time - t_wr, 5);
  end

  always @(negedge mem_dq_oe) if (armed && wr_seen)
    chk(($time - t_wr) >= 5, "R7 data hold (ns)", $time - t_wr, 5);

  always @(posedge mem_dq_oe) if (armed) begin
    t_dchg = $time;
    chk(($time - t_oer) >= 50, "R5 bus turnaround (ns)", $time - t_oer, 50);
    chk(mem_we_n == 1'b0, "R7 drive starts with write strobe", mem_we_n, 0);
  end

  always @(mem_addr) if (armed) begin
    if (wr_seen) chk(($time - t_wr) >= 10, "R8 address hold after write (ns)", $time - t_wr, 10);
    chk(($time - t_achg) >= 150, "R9 address change spacing (ns)", $time - t_achg, 150);
    t_achg = $time;
  end

  // output pins: true data only once every access window has elapsed
  initial begin
    #2;
    forever begin
      if (sel && !mem_oe_n && mem_we_n && ($time - t_sel) >= 150 &&
          ($time - t_achg) >= 150 && ($time - t_ofl) >= 70)
        mem_dq_in = sram[mem_addr];
      else
        mem_dq_in = sram[mem_addr] ^ 8'hA5;
      #5;
    end
  end

  // ---------------- cycle reference model ----------------
  int pcnt = NCYC, busy = 0, rcnt = 0, wcnt = 0;
  bit rflag = 0, m_acc = 0;
  logic [7:0] rexp = '0, pend = '0;

  task automatic step(input bit v, input bit w, input logic [12:0] a,
                      input logic [7:0] d, input bit pg);
    bit exp_rdy;
    @(negedge clk);
    exp_rdy = (pcnt == 0) && (busy == 0) && pwr_good;
    chk(req_ready == exp_rdy, "R2 req_ready", req_ready, exp_rdy);
    chk(rsp_valid == rflag, "R4 rsp_valid timing", rsp_valid, rflag);
    if (rflag && rsp_valid) chk(rsp_rdata == rexp, "R4 read data", rsp_rdata, rexp);
    if (pcnt > 0) chk(!mem_cs && mem_cs_n, "R1 deselected during power hold", mem_cs, 0);
    if (pcnt == 0 && busy == 0)
      chk(mem_we_n && mem_oe_n && !mem_dq_oe, "R3 idle strobes", {mem_we_n, mem_oe_n, mem_dq_oe}, 3'b110);
    if (rcnt > 0)
      chk(!mem_oe_n && mem_we_n && sel, "R3 read strobes", {mem_we_n, mem_oe_n, sel}, 3'b101);
    if (wcnt > 0)
      chk(!mem_we_n && mem_oe_n, "R6 write strobe low", {mem_we_n, mem_oe_n}, 2'b01);
    else if (pcnt == 0)
      chk(mem_we_n, "R6 write strobe high outside pulse", mem_we_n, 1);
    req_valid = v; req_write = w; req_addr = a; req_wdata = d; pwr_good = pg;
    m_acc = 0; rflag = 0;
    if (!pg) begin
      pcnt = NCYC; busy = 0; rcnt = 0; wcnt = 0;
    end else begin
      if (rcnt > 0) begin rcnt--; if (rcnt == 0) begin rflag = 1; rexp = pend; end end
      if (wcnt > 0) wcnt--;
      if (busy > 0) busy--;
      else if (pcnt > 0) pcnt--;
      else if (v) begin
        m_acc = 1;
        if (w) begin busy = WTOT; wcnt = WPL; shadow[a] = d; end
        else   begin busy = RTOT; rcnt = RDL; pend = shadow[a]; end
      end
    end
  endtask

  task automatic op(input bit w, input logic [12:0] a, input logic [7:0] d);
    do step(1'b1, w, a, d, 1'b1); while (!m_acc);
  endtask

  task automatic idle(input int n, input bit pg);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 13'h0, 8'h00, pg);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(req_ready == 0, "R1 reset ready", req_ready, 0);
    chk(mem_cs == 0 && mem_cs_n == 1, "R1 reset selects", {mem_cs, mem_cs_n}, 2'b01);
    chk(mem_we_n == 1 && mem_oe_n == 1, "R1 reset strobes", {mem_we_n, mem_oe_n}, 2'b11);
    chk(mem_dq_oe == 0, "R1 reset bus released", mem_dq_oe, 0);
    chk(rsp_valid == 0, "R1 reset rsp_valid", rsp_valid, 0);
    rst_n = 1'b1;
    armed = 1'b1;
    // R1 requests refused while power is low
    for (int i = 0; i < 6; i++) step(1'b1, 1'b1, 13'h0015, 8'h77, 1'b0);
    // R2 held request waits through the power hold
    op(1'b1, 13'h0000, 8'h3C);
    op(1'b1, 13'h1FFF, 8'hC3);
    op(1'b1, 13'h0AAA, 8'h5A);
    op(1'b0, 13'h0000, 8'h00);   // R4 read back
    op(1'b0, 13'h1FFF, 8'h00);
    op(1'b0, 13'h0AAA, 8'h00);
    op(1'b0, 13'h0015, 8'h00);   // R4 refused write left no trace
    op(1'b1, 13'h0AAA, 8'hFF);   // R5 write right after a read
    op(1'b0, 13'h0AAA, 8'h00);
    idle(4, 1'b1);
    // R1 power drop while idle, then recovery
    idle(3, 1'b0);
    op(1'b0, 13'h1FFF, 8'h00);
    idle(3, 1'b1);
    // mixed traffic over a small and a full address range
    for (int i = 0; i < 200; i++) begin
      logic [12:0] a;
      a = (i % 3 == 0) ? 13'($urandom) : 13'($urandom_range(0, 15));
      op(1'($urandom), a, 8'($urandom));
      if ($urandom_range(0, 3) == 0) idle($urandom_range(1, 4), 1'b1);
    end
    idle(RTOT + 4, 1'b1);
    // R4 memory model content equals the written data
    for (int i = 0; i < 16; i++)
      chk(sram[i] == shadow[i], "R4 memory content", sram[i], shadow[i]);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog expired: actual=1 expected=0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule